// File: doc/BRIEF.md
# AC-link Transmit Frame Serializer

This block produces the outgoing serial stream of an AC-link, the time-division-multiplexed audio link between a controller and one or more codecs. It runs on the bit clock supplied by the codec, drives the frame sync line and the serial data-out line, and sends one 256-bit frame every 256 bit clocks, with no gap between frames. Each frame has a 16-bit tag slot followed by twelve 20-bit data slots.

The surrounding controller presents the frame contents on a flat parallel interface:
- a codec register command: direction, 7-bit register index and 16-bit write data;
- a 2-bit codec select;
- left and right PCM samples, each with its own valid flag;
- a modem sample with its own valid flag.

The serializer captures these inputs at the first bit of every frame. It builds the tag from whichever inputs are valid, places each field at a fixed position in its slot, and shifts the frame out most significant bit first.

The GPIO output word has no separate input. It is taken from any command that writes register index 0x54. Slot 12 starts out invalid. From the frame after the first such write onwards, slot 12 carries the last word written to 0x54 in every frame, until the next reset.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bit clocks long: a 16-bit tag slot followed by twelve 20-bit slots. Frames follow one another with no idle bit clocks, so sync rises exactly every 256 bit clocks.
- R2: sync is high for the 16 bit clocks of the tag slot and low for the other 240. While rst_n is low, sync and sdout are both held low.
- R3: sync and sdout change only on the rising bit clock edge. Each slot is sent most significant bit first: tag bit 15 first, then bit 19 of each data slot.
- R4: The tag carries the following bits. Bit 15 is the frame-valid flag and is 1 exactly when at least one of bits 14 to 3 is 1. Bit (15-k) is the valid flag of slot k, for k = 1 to 12. Bit 2 is 0. Bits 1:0 carry codec_id.
- R5: When cmd_valid is 1, slot 1 is valid and holds the following fields. Bit 19 is cmd_read (1 = read). Bits 18:12 hold cmd_index. Bits 11:0 are 0. Slot 2 is valid only for a write (cmd_valid=1 and cmd_read=0); it then holds cmd_wdata in bits 19:4 with bits 3:0 at 0.
- R6: When pcm_l_valid is 1, slot 3 is valid and holds pcm_l left-justified, with its trailing bits at 0. When pcm_r_valid is 1, slot 4 is valid and holds pcm_r in the same way.
- R7: When modem_valid is 1, slot 5 is valid and holds the modem sample left-justified, with its trailing bits at 0.
- R8: Slots 6 to 11 are always invalid and all zero. Any slot whose valid flag is 0 is sent as all zeros, whatever its data input holds.
- R9: All slot inputs, including codec_id, are sampled on the rising edge that sends tag bit 15. Changes after that edge do not affect the frame in progress.
- R10: Slot 12 is invalid after reset. A write command to index 0x54 does not change slot 12 in its own frame. In the next frame, slot 12 is valid and carries the written data in bits 19:4, with bits 3:0 at 0.
- R11: Once valid, slot 12 stays valid in every later frame and repeats the last data written to index 0x54. Reads of 0x54 and writes to other indices leave it unchanged. Only rst_n clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A codec register command is present for the next frame |
| cmd_read | input | 1 | Command direction: 1 = read, 0 = write |
| cmd_index | input | 7 | Codec register index |
| cmd_wdata | input | 16 | Write data for a write command |
| codec_id | input | 2 | Codec select sent in tag bits 1:0 (0 = primary) |
| pcm_l_valid | input | 1 | Left PCM sample is valid |
| pcm_l | input | PCM_W | Left PCM sample |
| pcm_r_valid | input | 1 | Right PCM sample is valid |
| pcm_r | input | PCM_W | Right PCM sample |
| modem_valid | input | 1 | Modem sample is valid |
| modem | input | MODEM_W | Modem sample |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdout | output | 1 | Serial frame data |

## Verification
The frame position counter is the main internal state. If it is wrong, sync rises at the wrong spacing or stays high for the wrong number of bit clocks, and this is visible within one frame. The captured slot contents pass through only one parallel load and then the shift register. An error there appears in the very frame it affects, as a wrong tag flag or a wrong bit at a known offset within a slot.

The slot-12 store is the only state that persists across frames. If it is wrong, the error shows in the frame after the write to 0x54, or in the frames after a write to another index or a read of 0x54. For that reason the sequence keeps that store under observation for several frames and across a reset.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int N_SLOT  = 12;
  localparam int BODY_W  = SLOT_W * N_SLOT;
  localparam int FRAME_W = TAG_W + BODY_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int IDX_W   = 7;
  localparam int REG_W   = 16;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [TAG_W-1:0]  tag_t;

  // Tag word: bit 15 = any slot valid, bit (15-k) = slot k valid, bits 1:0 = codec select
  function automatic tag_t make_tag(input logic [N_SLOT:1] slot_vld, input logic [1:0] sel);
    tag_t t;
    t = '0;
    t[TAG_W-1] = |slot_vld;
    for (int k = 1; k <= N_SLOT; k++) begin
      t[TAG_W-1-k] = slot_vld[k];
    end
    t[1:0] = sel;
    return t;
  endfunction

  // Command address slot: direction, index, then zero padding
  function automatic slot_t cmd_addr_slot(input logic rd, input logic [IDX_W-1:0] idx);
    return {rd, idx, {(SLOT_W-1-IDX_W){1'b0}}};
  endfunction

  // 16-bit register word placed in the upper bits of a slot
  function automatic slot_t reg_word_slot(input logic [REG_W-1:0] w);
    return {w, {(SLOT_W-REG_W){1'b0}}};
  endfunction

endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer
  import aclink_tx_pkg::*;
(
  input  logic bclk,
  input  logic rst_n,
  output logic frame_start,
  output logic sync_q
);

  logic [CNT_W-1:0] bit_pos;

  assign frame_start = (bit_pos == '0);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
      sync_q  <= 1'b0;
    end else begin
      bit_pos <= (bit_pos == CNT_W'(FRAME_W-1)) ? '0 : bit_pos + 1'b1;
      sync_q  <= (bit_pos < CNT_W'(TAG_W));
    end
  end

  // Observers: spacing of sync rises and width of the high phase
  logic             sync_prev;
  logic             seen_rise;
  logic [CNT_W:0]   since_rise;
  logic [CNT_W:0]   high_run;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev  <= 1'b0;
      seen_rise  <= 1'b0;
      since_rise <= '0;
      high_run   <= '0;
    end else begin
      sync_prev <= sync_q;
      if (sync_q && !sync_prev) begin
        since_rise <= (CNT_W+1)'(1);
        seen_rise  <= 1'b1;
      end else begin
        since_rise <= since_rise + 1'b1;
      end
      high_run <= sync_q ? high_run + 1'b1 : '0;
    end
  end

  p_frame_period_r1: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_q && !sync_prev && seen_rise) |-> (since_rise == (CNT_W+1)'(FRAME_W)));

  p_sync_width_r2: assert property (@(posedge bclk) disable iff (!rst_n)
    (!sync_q && sync_prev) |-> (high_run == (CNT_W+1)'(TAG_W)));

endmodule

// File: rtl/aclink_slot12_hold.sv
module aclink_slot12_hold
  import aclink_tx_pkg::*;
#(
  parameter logic [IDX_W-1:0] GPIO_INDEX = 7'h54
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic             gpio_valid,
  output logic [REG_W-1:0] gpio_data,
  output logic             gpio_write
);

  assign gpio_write = capture && cmd_valid && !cmd_read && (cmd_index == GPIO_INDEX);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_valid <= 1'b0;
      gpio_data  <= '0;
    end else if (gpio_write) begin
      gpio_valid <= 1'b1;
      gpio_data  <= cmd_wdata;
    end
  end

  p_gpio_load_r10: assert property (@(posedge bclk) disable iff (!rst_n)
    gpio_write |=> (gpio_valid && gpio_data == $past(cmd_wdata)));

  p_gpio_sticky_r11: assert property (@(posedge bclk) disable iff (!rst_n)
    gpio_valid |=> gpio_valid);

  p_gpio_hold_r11: assert property (@(posedge bclk) disable iff (!rst_n)
    !gpio_write |=> $stable(gpio_data));

endmodule

// File: rtl/aclink_slot_assembler.sv
module aclink_slot_assembler
  import aclink_tx_pkg::*;
#(
  parameter int PCM_W   = 16,
  parameter int MODEM_W = 16
) (
  input  logic               cmd_valid,
  input  logic               cmd_read,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic [REG_W-1:0]   cmd_wdata,
  input  logic [1:0]         codec_id,
  input  logic               pcm_l_valid,
  input  logic [PCM_W-1:0]   pcm_l,
  input  logic               pcm_r_valid,
  input  logic [PCM_W-1:0]   pcm_r,
  input  logic               modem_valid,
  input  logic [MODEM_W-1:0] modem,
  input  logic               gpio_valid,
  input  logic [REG_W-1:0]   gpio_data,
  output logic [FRAME_W-1:0] frame_word
);

  localparam int N_RSVD = 6;

  slot_t l_just, r_just, m_just;

  generate
    if (PCM_W == SLOT_W) begin : g_pcm_full
      assign l_just = pcm_l;
      assign r_just = pcm_r;
    end else begin : g_pcm_pad
      assign l_just = {pcm_l, {(SLOT_W-PCM_W){1'b0}}};
      assign r_just = {pcm_r, {(SLOT_W-PCM_W){1'b0}}};
    end
    if (MODEM_W == SLOT_W) begin : g_mdm_full
      assign m_just = modem;
    end else begin : g_mdm_pad
      assign m_just = {modem, {(SLOT_W-MODEM_W){1'b0}}};
    end
  endgenerate

  logic              cmd_write;
  logic [N_SLOT:1]   slot_vld;
  slot_t             s_addr, s_data, s_left, s_right, s_modem, s_gpio;

  assign cmd_write = cmd_valid && !cmd_read;

  always_comb begin
    slot_vld     = '0;
    slot_vld[1]  = cmd_valid;
    slot_vld[2]  = cmd_write;
    slot_vld[3]  = pcm_l_valid;
    slot_vld[4]  = pcm_r_valid;
    slot_vld[5]  = modem_valid;
    slot_vld[12] = gpio_valid;
  end

  assign s_addr  = cmd_valid   ? cmd_addr_slot(cmd_read, cmd_index) : '0;
  assign s_data  = cmd_write   ? reg_word_slot(cmd_wdata)           : '0;
  assign s_left  = pcm_l_valid ? l_just                             : '0;
  assign s_right = pcm_r_valid ? r_just                             : '0;
  assign s_modem = modem_valid ? m_just                             : '0;
  assign s_gpio  = gpio_valid  ? reg_word_slot(gpio_data)           : '0;

  assign frame_word = {make_tag(slot_vld, codec_id),
                       s_addr, s_data, s_left, s_right, s_modem,
                       {(N_RSVD*SLOT_W){1'b0}},
                       s_gpio};

endmodule

// File: rtl/aclink_frame_shifter.sv
module aclink_frame_shifter
  import aclink_tx_pkg::*;
(
  input  logic               bclk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               sdout_q
);

  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      sdout_q <= 1'b0;
    end else if (load) begin
      sdout_q <= frame_word[FRAME_W-1];
      shreg   <= {frame_word[FRAME_W-2:0], 1'b0};
    end else begin
      sdout_q <= shreg[FRAME_W-1];
      shreg   <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int               PCM_W      = 16,
  parameter int               MODEM_W    = 16,
  parameter logic [IDX_W-1:0] GPIO_INDEX = 7'h54
) (
  input  logic               bclk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_read,
  input  logic [6:0]         cmd_index,
  input  logic [15:0]        cmd_wdata,
  input  logic [1:0]         codec_id,
  input  logic               pcm_l_valid,
  input  logic [PCM_W-1:0]   pcm_l,
  input  logic               pcm_r_valid,
  input  logic [PCM_W-1:0]   pcm_r,
  input  logic               modem_valid,
  input  logic [MODEM_W-1:0] modem,
  output logic               sync,
  output logic               sdout
);

  logic               frame_start;
  logic               gpio_valid;
  logic [REG_W-1:0]   gpio_data;
  logic               gpio_write;
  logic [FRAME_W-1:0] frame_word;

  aclink_bit_timer u_timer (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sync_q      (sync)
  );

  aclink_slot12_hold #(.GPIO_INDEX(GPIO_INDEX)) u_slot12 (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .capture    (frame_start),
    .cmd_valid  (cmd_valid),
    .cmd_read   (cmd_read),
    .cmd_index  (cmd_index),
    .cmd_wdata  (cmd_wdata),
    .gpio_valid (gpio_valid),
    .gpio_data  (gpio_data),
    .gpio_write (gpio_write)
  );

  aclink_slot_assembler #(.PCM_W(PCM_W), .MODEM_W(MODEM_W)) u_assemble (
    .cmd_valid   (cmd_valid),
    .cmd_read    (cmd_read),
    .cmd_index   (cmd_index),
    .cmd_wdata   (cmd_wdata),
    .codec_id    (codec_id),
    .pcm_l_valid (pcm_l_valid),
    .pcm_l       (pcm_l),
    .pcm_r_valid (pcm_r_valid),
    .pcm_r       (pcm_r),
    .modem_valid (modem_valid),
    .modem       (modem),
    .gpio_valid  (gpio_valid),
    .gpio_data   (gpio_data),
    .frame_word  (frame_word)
  );

  aclink_frame_shifter u_shift (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .frame_word (frame_word),
    .sdout_q    (sdout)
  );

  // Frame-valid flag agrees with the inputs and the slot-12 store at capture
  p_frame_valid_r4: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |-> (frame_word[FRAME_W-1] ==
                     (cmd_valid | pcm_l_valid | pcm_r_valid | modem_valid | gpio_valid)));

  // Codec select lands in the two lowest tag bits
  p_codec_sel_r4: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |-> (frame_word[BODY_W+1:BODY_W] == codec_id));

endmodule

// File: tb/aclink_tx_framer_bench.sv
module aclink_tx_framer_bench;

  localparam int PW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid, cmd_read;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_wdata;
  logic [1:0]  codec_id;
  logic        pcm_l_valid, pcm_r_valid, modem_valid;
  logic [PW-1:0] pcm_l, pcm_r;
  logic [15:0] modem;
  logic        sync, sdout;

  always #5 clk = ~clk;

  aclink_tx_framer u_aclink_tx_framer (
    .bclk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_index(cmd_index),
    .cmd_wdata(cmd_wdata), .codec_id(codec_id),
    .pcm_l_valid(pcm_l_valid), .pcm_l(pcm_l),
    .pcm_r_valid(pcm_r_valid), .pcm_r(pcm_r),
    .modem_valid(modem_valid), .modem(modem),
    .sync(sync), .sdout(sdout)
  );

  int checks = 0;
  int fails  = 0;
  int begun  = 0;
  int done   = 0;
  logic [255:0] expq [$];

  // Bench-side model of the slot-12 store
  bit          m_gv = 1'b0;
  logic [15:0] m_gd = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] slot_of(input logic [255:0] f, input int k);
    return f[239 - 20*(k-1) -: 20];
  endfunction

  // Driver: present inputs for the next frame and queue the frame they should give
  task automatic apply(input bit cv, input bit rd, input logic [6:0] ix, input logic [15:0] wd,
                       input logic [1:0] id, input bit lv, input logic [15:0] l,
                       input bit rv, input logic [15:0] r, input bit mv, input logic [15:0] m);
    logic [12:1]  v;
    logic [19:0]  sl [1:12];
    logic [15:0]  tag;
    logic [255:0] f;
    cmd_valid = cv; cmd_read = rd; cmd_index = ix; cmd_wdata = wd; codec_id = id;
    pcm_l_valid = lv; pcm_l = l; pcm_r_valid = rv; pcm_r = r; modem_valid = mv; modem = m;
    v = '0;
    for (int k = 1; k <= 12; k++) sl[k] = 20'h0;
    if (cv) begin
      v[1] = 1'b1; sl[1] = {rd, ix, 12'h000};
      if (!rd) begin v[2] = 1'b1; sl[2] = {wd, 4'h0}; end
    end
    if (lv) begin v[3] = 1'b1; sl[3] = {l, 4'h0}; end
    if (rv) begin v[4] = 1'b1; sl[4] = {r, 4'h0}; end
    if (mv) begin v[5] = 1'b1; sl[5] = {m, 4'h0}; end
    if (m_gv) begin v[12] = 1'b1; sl[12] = {m_gd, 4'h0}; end
    tag = '0;
    tag[15] = |v;
    for (int k = 1; k <= 12; k++) tag[15-k] = v[k];
    tag[1:0] = id;
    f = '0;
    f[255:240] = tag;
    for (int k = 1; k <= 12; k++) f[239 - 20*(k-1) -: 20] = sl[k];
    expq.push_back(f);
    if (cv && !rd && ix == 7'h54) begin m_gv = 1'b1; m_gd = wd; end
  endtask

  // Monitor: deserialize on the falling edge and compare against the queue
  int           idx = 0;
  bit           started = 1'b0;
  logic         prev_sync = 1'b0;
  logic [255:0] got;
  int           sync_err = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0; started = 1'b0; prev_sync = 1'b0;
    end else begin
      if (sync && !prev_sync) begin
        if (started) chk("R1", "bits between sync rises", idx, 256);
        started = 1'b1; idx = 0; sync_err = 0; begun++;
      end
      if (started && idx < 256) begin
        got[255-idx] = sdout;
        if (sync !== (idx < 16)) sync_err++;
        idx++;
        if (idx == 256) begin
          logic [255:0] e;
          done++;
          chk("R2", "sync misplaced bits", sync_err, 0);
          if (expq.size() > 0) begin
            e = expq.pop_front();
            chk("R4", "tag", {16'h0, got[255:240]}, {16'h0, e[255:240]});
            chk("R5 R3", "slot1", {12'h0, slot_of(got,1)}, {12'h0, slot_of(e,1)});
            chk("R5", "slot2", {12'h0, slot_of(got,2)}, {12'h0, slot_of(e,2)});
            chk("R6", "slot3", {12'h0, slot_of(got,3)}, {12'h0, slot_of(e,3)});
            chk("R6", "slot4", {12'h0, slot_of(got,4)}, {12'h0, slot_of(e,4)});
            chk("R7", "slot5", {12'h0, slot_of(got,5)}, {12'h0, slot_of(e,5)});
            for (int k = 6; k <= 11; k++)
              chk("R8", $sformatf("slot%0d", k), {12'h0, slot_of(got,k)}, 32'h0);
            chk("R10 R11", "slot12", {12'h0, slot_of(got,12)}, {12'h0, slot_of(e,12)});
            chk("R9", "whole frame", {31'h0, got == e}, 32'h1);
          end
        end
      end
      prev_sync = sync;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    apply(0, 0, 7'h00, 16'h0000, 2'b00, 0, 16'h0, 0, 16'h0, 0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R2", "sync in reset", {31'h0, sync}, 32'h0);
    chk("R2", "sdout in reset", {31'h0, sdout}, 32'h0);
    rst_n = 1'b1;
    // frame 1: write to an ordinary register, both PCM channels (R5 R6)
    wait (begun == 1);
    apply(1, 0, 7'h02, 16'h8A5C, 2'b00, 1, 16'h1234, 1, 16'hFEDC, 0, 16'h0);
    // frame 2: read, secondary codec, modem only; PCM data present but invalid (R7 R8)
    wait (begun == 2);
    apply(1, 1, 7'h7E, 16'hFFFF, 2'b01, 0, 16'hAAAA, 0, 16'h5555, 1, 16'hC3A5);
    // frame 3: write to 0x54, slot 12 still invalid in this frame (R10)
    wait (begun == 3);
    apply(1, 0, 7'h54, 16'hBEEF, 2'b11, 0, 16'h0, 0, 16'h0, 0, 16'h0);
    // frame 4: slot 12 now valid with BEEF (R10)
    wait (begun == 4);
    apply(0, 0, 7'h00, 16'h0, 2'b00, 1, 16'h8001, 0, 16'h0, 0, 16'h0);
    // frame 5: nothing else valid, slot 12 alone keeps frame valid (R11 R4)
    wait (begun == 5);
    apply(0, 0, 7'h54, 16'h1111, 2'b10, 0, 16'h0, 0, 16'h0, 0, 16'h0);
    // frame 6: read of 0x54 leaves slot 12 unchanged (R11)
    wait (begun == 6);
    apply(1, 1, 7'h54, 16'h2222, 2'b00, 0, 16'h0, 0, 16'h0, 0, 16'h0);
    // frame 7: new write to 0x54, old data this frame (R11)
    wait (begun == 7);
    apply(1, 0, 7'h54, 16'h1357, 2'b00, 0, 16'h0, 1, 16'h7FFF, 0, 16'h0);
    // frame 8: write elsewhere, slot 12 shows 1357 (R11)
    wait (begun == 8);
    apply(1, 0, 7'h20, 16'h0F0F, 2'b00, 0, 16'h0, 0, 16'h0, 1, 16'h0001);
    wait (done == 9);
    rst_n = 1'b0;
    #1;
    chk("R2", "sync after reset", {31'h0, sync}, 32'h0);
    chk("R2", "sdout after reset", {31'h0, sdout}, 32'h0);
    expq.delete();
    m_gv = 1'b0; m_gd = '0;
    // after reset slot 12 is invalid again (R10)
    apply(0, 0, 7'h00, 16'h0, 2'b00, 0, 16'h0, 1, 16'h0001, 0, 16'h0);
    repeat (4) @(negedge clk);
    begin
      int b0;
      b0 = begun;
      rst_n = 1'b1;
      wait (begun == b0 + 1);
    end
    apply(0, 0, 7'h00, 16'h0, 2'b00, 0, 16'h0, 0, 16'h0, 0, 16'h0);
    wait (done == 11);
    finish_run();
  end

endmodule